// File: doc/BRIEF.md
# Segmented Operand Address Generator

This unit turns the addressing fields of a memory operand into the address a bus cycle needs. A 16-bit offset is formed from an optional base register (BX or BP), an optional index register (SI or DI) and an optional displacement. The displacement is either a full 16-bit word or a byte that is sign-extended. The unit then picks one of four segment registers and forms the 20-bit physical address as the segment value times sixteen plus the offset. Any carry out of bit 19 is dropped.

The default segment follows the base register. BP-based forms use the stack segment, and every other form uses the data segment. An explicit override, when enabled, replaces that default. The upstream decoder presents one request per cycle with `req_valid`. The results appear on the registered outputs one clock later, together with `out_valid`.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_offset`, `out_seg`, `out_phys` and `out_seg_sel` are all zero.
- R2: `out_valid` in a cycle equals `req_valid` sampled at the previous rising edge, and the other outputs reflect the inputs sampled at that same edge.
- R3: When `req_valid` is low at an edge, `out_offset`, `out_seg_sel`, `out_seg` and `out_phys` keep their previous values.
- R4: Direct mode (`mode` 0) and the unused codes 5 to 7 take all 16 bits of `disp` as the offset. In these modes the base and index selects, the register values and `disp_wide` have no effect.
- R5: Register-indirect mode (`mode` 1) uses as offset the sum of the selected base and the selected index, with no displacement. `base_sel` is 1 for BX and 2 for BP, and 0 or 3 for none. `idx_sel` is 1 for SI and 2 for DI, and 0 or 3 for none. A register that is not selected contributes zero.
- R6: Register-relative mode (`mode` 2) adds the displacement to the selected base or index register.
- R7: Base-indexed mode (`mode` 3) adds base and index. Relative base-indexed mode (`mode` 4) also adds the displacement.
- R8: With `disp_wide` = 0, the displacement is `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` is ignored. With `disp_wide` = 1, all of `disp` is used.
- R9: The offset sum wraps modulo 65536.
- R10: Without an override, the segment is SS (code 2) when `mode` is 1 to 4 and `base_sel` is 2. In every other case it is DS (code 3).
- R11: With `seg_ovr_en` = 1, the segment code is `seg_ovr_sel`, where 0 = ES, 1 = CS, 2 = SS and 3 = DS. `out_seg` carries that register's value.
- R12: `out_phys` equals (`out_seg` × 16 + `out_offset`) modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing form code |
| base_sel | input | 2 | Base register select |
| idx_sel | input | 2 | Index register select |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = sign-extended byte |
| disp | input | 16 | Displacement or direct offset |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_ovr_en | input | 1 | Segment override enable |
| seg_ovr_sel | input | 2 | Override segment code |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| out_valid | output | 1 | Result strobe |
| out_seg_sel | output | 2 | Chosen segment code |
| out_seg | output | 16 | Chosen segment value |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |

## Verification
The assertions assume that every addressing input carries a defined value in any cycle where `req_valid` is high. They also assume that `seg_ovr_sel` is only meaningful while `seg_ovr_en` is set. The bench drives all inputs on the falling clock edge with fully defined values, including the unused mode and select codes. Its random phase draws every field independently, so held cycles, overrides and wraparound cases all occur under those assumptions.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int OFS_W  = 16;
  parameter int SEG_W  = 16;
  parameter int SHIFT  = 4;
  parameter int PA_W   = 20;
  parameter int NARROW = 8;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 3;
  localparam int NSEG   = 1 << SEL_W;

  localparam logic [MODE_W-1:0] AM_DIRECT   = 3'd0;
  localparam logic [MODE_W-1:0] AM_REG      = 3'd1;
  localparam logic [MODE_W-1:0] AM_REG_DISP = 3'd2;
  localparam logic [MODE_W-1:0] AM_BIX      = 3'd3;
  localparam logic [MODE_W-1:0] AM_BIX_DISP = 3'd4;

  localparam logic [SEL_W-1:0] BSEL_BX = 2'd1;
  localparam logic [SEL_W-1:0] BSEL_BP = 2'd2;
  localparam logic [SEL_W-1:0] ISEL_SI = 2'd1;
  localparam logic [SEL_W-1:0] ISEL_DI = 2'd2;

  localparam logic [SEL_W-1:0] SEG_ES = 2'd0;
  localparam logic [SEL_W-1:0] SEG_CS = 2'd1;
  localparam logic [SEL_W-1:0] SEG_SS = 2'd2;
  localparam logic [SEL_W-1:0] SEG_DS = 2'd3;

  // Byte displacement sign-extended, or the full word passed through
  function automatic logic [OFS_W-1:0] widen_disp(input logic [OFS_W-1:0] d,
                                                  input logic wide);
    if (wide) return d;
    return {{(OFS_W-NARROW){d[NARROW-1]}}, d[NARROW-1:0]};
  endfunction

  // Segment shifted by SHIFT plus offset, truncated to PA_W bits
  function automatic logic [PA_W-1:0] phys_of(input logic [SEG_W-1:0] seg,
                                              input logic [OFS_W-1:0] ofs);
    logic [SEG_W+SHIFT-1:0] base;
    base = {seg, {SHIFT{1'b0}}};
    return PA_W'(base + (SEG_W+SHIFT)'(ofs));
  endfunction
endpackage

// File: rtl/ea_offset_unit.sv
module ea_offset_unit
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [SEL_W-1:0]  idx_sel,
  input  logic              disp_wide,
  input  logic [OFS_W-1:0]  disp,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  output logic [OFS_W-1:0]  offset,
  output logic              uses_bp
);
  logic [OFS_W-1:0] bval, ival, dval;
  logic             uses_regs;

  always_comb begin
    bval = '0;
    ival = '0;
    case (base_sel)
      BSEL_BX: bval = reg_bx;
      BSEL_BP: bval = reg_bp;
      default: bval = '0;
    endcase
    case (idx_sel)
      ISEL_SI: ival = reg_si;
      ISEL_DI: ival = reg_di;
      default: ival = '0;
    endcase
    dval = widen_disp(disp, disp_wide);
    uses_regs = 1'b1;
    case (mode)
      AM_REG, AM_BIX:           offset = bval + ival;
      AM_REG_DISP, AM_BIX_DISP: offset = bval + ival + dval;
      default: begin
        offset    = disp;
        uses_regs = 1'b0;
      end
    endcase
    uses_bp = uses_regs && (base_sel == BSEL_BP);
  end
endmodule

// File: rtl/ea_segment_select.sv
module ea_segment_select
  import ea_pkg::*;
(
  input  logic              uses_bp,
  input  logic              ovr_en,
  input  logic [SEL_W-1:0]  ovr_sel,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_ds,
  output logic [SEL_W-1:0]  seg_code,
  output logic [SEG_W-1:0]  seg_val
);
  logic [NSEG-1:0][SEG_W-1:0] bank;
  logic [NSEG-1:0]            hit;

  assign bank[SEG_ES] = seg_es;
  assign bank[SEG_CS] = seg_cs;
  assign bank[SEG_SS] = seg_ss;
  assign bank[SEG_DS] = seg_ds;

  assign seg_code = ovr_en  ? ovr_sel :
                    uses_bp ? SEG_SS  : SEG_DS;

  // One-hot pick of the segment register value
  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_hit
      assign hit[g] = (seg_code == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    seg_val = '0;
    for (int k = 0; k < NSEG; k++)
      if (hit[k]) seg_val = bank[k];
  end
endmodule

// File: rtl/ea_phys_calc.sv
module ea_phys_calc
  import ea_pkg::*;
(
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFS_W-1:0] offset,
  output logic [PA_W-1:0]  phys
);
  assign phys = phys_of(seg_val, offset);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [SEL_W-1:0]  idx_sel,
  input  logic              disp_wide,
  input  logic [OFS_W-1:0]  disp,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  input  logic              seg_ovr_en,
  input  logic [SEL_W-1:0]  seg_ovr_sel,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_ds,
  output logic              out_valid,
  output logic [SEL_W-1:0]  out_seg_sel,
  output logic [SEG_W-1:0]  out_seg,
  output logic [OFS_W-1:0]  out_offset,
  output logic [PA_W-1:0]   out_phys
);
  logic [OFS_W-1:0] nxt_offset;
  logic             nxt_uses_bp;
  logic [SEL_W-1:0] nxt_seg_sel;
  logic [SEG_W-1:0] nxt_seg;
  logic [PA_W-1:0]  nxt_phys;

  ea_offset_unit u_ofs (
    .mode(mode), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp_wide(disp_wide), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .offset(nxt_offset), .uses_bp(nxt_uses_bp)
  );

  ea_segment_select u_seg (
    .uses_bp(nxt_uses_bp), .ovr_en(seg_ovr_en), .ovr_sel(seg_ovr_sel),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_code(nxt_seg_sel), .seg_val(nxt_seg)
  );

  ea_phys_calc u_pa (
    .seg_val(nxt_seg), .offset(nxt_offset), .phys(nxt_phys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_seg_sel <= '0;
      out_seg     <= '0;
      out_offset  <= '0;
      out_phys    <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_seg_sel <= nxt_seg_sel;
        out_seg     <= nxt_seg;
        out_offset  <= nxt_offset;
        out_phys    <= nxt_phys;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [MODE_W-1:0] mode,
  input logic [SEL_W-1:0]  base_sel,
  input logic [OFS_W-1:0]  disp,
  input logic              seg_ovr_en,
  input logic [SEL_W-1:0]  seg_ovr_sel,
  input logic              nxt_uses_bp,
  input logic              out_valid,
  input logic [SEL_W-1:0]  out_seg_sel,
  input logic [SEG_W-1:0]  out_seg,
  input logic [OFS_W-1:0]  out_offset,
  input logic [PA_W-1:0]   out_phys
);
  logic reg_form;
  assign reg_form = (mode >= AM_REG) && (mode <= AM_BIX_DISP);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_offset) && $stable(out_phys) &&
                    $stable(out_seg) && $stable(out_seg_sel)));

  // R4
  direct_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !reg_form) |=> (out_offset == $past(disp)));

  // R10
  stack_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seg_ovr_en && reg_form && base_sel == BSEL_BP)
      |=> (out_seg_sel == SEG_SS));

  // R10
  bp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_uses_bp && !reg_form) |-> 1'b0);

  // R11
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_ovr_en) |=> (out_seg_sel == $past(seg_ovr_sel)));

  // R12
  phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_phys == PA_W'({4'b0, out_seg, 4'b0} + {8'b0, out_offset})));
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
  .base_sel(base_sel), .disp(disp), .seg_ovr_en(seg_ovr_en),
  .seg_ovr_sel(seg_ovr_sel), .nxt_uses_bp(nxt_uses_bp),
  .out_valid(out_valid), .out_seg_sel(out_seg_sel), .out_seg(out_seg),
  .out_offset(out_offset), .out_phys(out_phys)
);

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  base_sel = '0, idx_sel = '0, seg_ovr_sel = '0;
  logic        disp_wide = 1'b0, seg_ovr_en = 1'b0;
  logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        out_valid;
  logic [1:0]  out_seg_sel;
  logic [15:0] out_seg, out_offset;
  logic [19:0] out_phys;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int e_valid = 0, e_sel = 0, e_seg = 0, e_off = 0, e_phys = 0;

  always #10 clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_sel(base_sel), .idx_sel(idx_sel), .disp_wide(disp_wide), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_ovr_en(seg_ovr_en), .seg_ovr_sel(seg_ovr_sel),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .out_seg_sel(out_seg_sel), .out_seg(out_seg),
    .out_offset(out_offset), .out_phys(out_phys)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural model of one accepted request
  task automatic model_update();
    int b, i, d, sum, s;
    e_valid = req_valid;
    if (!req_valid) return;
    b = (base_sel == 1) ? int'(reg_bx) : (base_sel == 2) ? int'(reg_bp) : 0;
    i = (idx_sel == 1) ? int'(reg_si) : (idx_sel == 2) ? int'(reg_di) : 0;
    if (disp_wide) d = int'(disp);
    else d = (disp[7] ? int'(disp[7:0]) - 256 : int'(disp[7:0]));
    if (mode == 1 || mode == 3) sum = b + i;
    else if (mode == 2 || mode == 4) sum = b + i + d;
    else sum = int'(disp);
    e_off = ((sum % 65536) + 65536) % 65536;
    if (seg_ovr_en) s = int'(seg_ovr_sel);
    else if (mode >= 1 && mode <= 4 && base_sel == 2) s = 2;
    else s = 3;
    e_sel = s;
    e_seg = (s == 0) ? int'(seg_es) : (s == 1) ? int'(seg_cs) :
            (s == 2) ? int'(seg_ss) : int'(seg_ds);
    e_phys = (e_seg * 16 + e_off) % 1048576;
  endtask

  // Inputs are already set (driven at a falling edge); clock once and compare
  task automatic step(input string tag);
    string st;
    bit held;
    held = !req_valid;
    @(posedge clk);
    model_update();
    @(negedge clk);
    st = seg_ovr_en ? "R11" : "R10";
    chk("R2", "valid", int'(out_valid), e_valid);
    chk(held ? "R3" : tag, "offset", int'(out_offset), e_off);
    chk(held ? "R3" : st, "seg_sel", int'(out_seg_sel), e_sel);
    chk(held ? "R3" : "R11", "seg", int'(out_seg), e_seg);
    chk(held ? "R3" : "R12", "phys", int'(out_phys), e_phys);
  endtask

  task automatic req(input logic [2:0] m, input logic [1:0] bs, input logic [1:0] is,
                     input logic w, input logic [15:0] d, input logic oe,
                     input logic [1:0] os, input string tag);
    req_valid = 1'b1; mode = m; base_sel = bs; idx_sel = is;
    disp_wide = w; disp = d; seg_ovr_en = oe; seg_ovr_sel = os;
    step(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0400;
    seg_es = 16'h4000; seg_cs = 16'h5000; seg_ss = 16'h6000; seg_ds = 16'h7000;
    req_valid = 1'b1; mode = 3'd2; disp = 16'h1234;
    repeat (3) @(negedge clk);
    // R1: reset state, with active inputs present
    chk("R1", "valid", int'(out_valid), 0);
    chk("R1", "offset", int'(out_offset), 0);
    chk("R1", "seg_sel", int'(out_seg_sel), 0);
    chk("R1", "seg", int'(out_seg), 0);
    chk("R1", "phys", int'(out_phys), 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R4 direct, registers and width ignored; codes 5..7 alike
    req(3'd0, 2'd2, 2'd1, 1'b0, 16'hABCD, 1'b0, 2'd0, "R4");
    req(3'd5, 2'd1, 2'd2, 1'b1, 16'h0F0F, 1'b0, 2'd0, "R4");
    req(3'd7, 2'd2, 2'd0, 1'b0, 16'h8001, 1'b0, 2'd0, "R4");
    // R5 register indirect: single regs and none
    req(3'd1, 2'd1, 2'd0, 1'b1, 16'h5555, 1'b0, 2'd0, "R5");
    req(3'd1, 2'd0, 2'd1, 1'b1, 16'h5555, 1'b0, 2'd0, "R5");
    req(3'd1, 2'd3, 2'd2, 1'b1, 16'h5555, 1'b0, 2'd0, "R5");
    req(3'd1, 2'd2, 2'd3, 1'b1, 16'h5555, 1'b0, 2'd0, "R10");
    // R6 register relative
    req(3'd2, 2'd1, 2'd0, 1'b1, 16'h0050, 1'b0, 2'd0, "R6");
    req(3'd2, 2'd0, 2'd2, 1'b1, 16'h1234, 1'b0, 2'd0, "R6");
    req(3'd2, 2'd2, 2'd0, 1'b0, 16'hFF7F, 1'b0, 2'd0, "R6");
    // R7 base indexed and relative base indexed
    req(3'd3, 2'd1, 2'd1, 1'b1, 16'h9999, 1'b0, 2'd0, "R7");
    req(3'd4, 2'd1, 2'd1, 1'b1, 16'h0050, 1'b0, 2'd0, "R7");
    req(3'd4, 2'd2, 2'd2, 1'b1, 16'h0002, 1'b0, 2'd0, "R7");
    // R8 narrow displacement: negative byte, upper bits ignored
    req(3'd2, 2'd1, 2'd0, 1'b0, 16'h1280, 1'b0, 2'd0, "R8");
    req(3'd2, 2'd1, 2'd0, 1'b0, 16'hFF7F, 1'b0, 2'd0, "R8");
    // R9 offset wrap
    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    req(3'd3, 2'd1, 2'd1, 1'b1, 16'h0000, 1'b0, 2'd0, "R9");
    reg_bx = 16'h0010;
    req(3'd2, 2'd1, 2'd0, 1'b0, 16'h00F0, 1'b0, 2'd0, "R9");
    // R11 overrides, including BP form redirected away from SS
    for (int k = 0; k < 4; k++)
      req(3'd4, 2'd2, 2'd1, 1'b1, 16'h0100, 1'b1, 2'(k), "R11");
    // R12 physical wrap past 2^20
    seg_ds = 16'hFFFF;
    req(3'd0, 2'd0, 2'd0, 1'b1, 16'h0010, 1'b0, 2'd0, "R12");
    req(3'd0, 2'd0, 2'd0, 1'b1, 16'hFFFF, 1'b0, 2'd0, "R12");
    // R3 hold: change every input while strobe is low
    req_valid = 1'b0; disp = 16'h3333; mode = 3'd1; seg_ovr_en = 1'b1;
    seg_ds = 16'h1111; reg_bx = 16'h7777;
    step("R3");
    step("R3");

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      req_valid = ($urandom % 4) != 0;
      mode = 3'($urandom); base_sel = 2'($urandom); idx_sel = 2'($urandom);
      disp_wide = 1'($urandom); disp = 16'($urandom);
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
      seg_ovr_en = ($urandom % 3) == 0; seg_ovr_sel = 2'($urandom);
      seg_es = 16'($urandom); seg_cs = 16'($urandom);
      seg_ss = 16'($urandom); seg_ds = 16'($urandom);
      step("R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule